// File: doc/BRIEF.md
# Sequential fixed-point FIR/IIR trial filter engine

This block filters one trial of single-channel signal samples with a filter chosen per user. A host first streams the coefficient words into the engine over a one-word-per-cycle port. It then pulses `start` and feeds the trial's samples over a valid/ready port. The engine computes each output with a single multiply-accumulate datapath, one tap per clock, and hands the result out over a second valid/ready port. After the last output of the trial it pulses `done`.

A one-bit mode selects a purely feedforward filter or a filter that also feeds back its own past outputs. Both filter kinds share the same coefficient banks, histories and accumulator. Taps above the chosen order are loaded as zero, so the datapath does not change with the order. All values are signed Q4.12: 16 bits, 12 of them fractional. Products keep full precision, and each result is scaled back to Q4.12 and saturated before it leaves the engine or enters the feedback history.

Top module: `trial_filter_engine`

## Requirements
- R1: While `rst_n` is low at a clock edge, the engine resets. After that edge `busy`, `done`, `coef_err`, `in_ready` and `out_valid` are all 0.
- R2: With mode 0 (feedforward), output i equals sat((sum over k < FIR_TAPS of b[k]·x[i−k]) >>> 12). The shift is arithmetic, so it rounds toward minus infinity.
- R3: With mode 1 (feedback), output i equals sat((sum over k < IIR_TAPS of b[k]·x[i−k] − sum over 1 ≤ k < IIR_TAPS of a[k]·y[i−k]) >>> 12). Each y is the saturated value that was output earlier, and a[0] is never used.
- R4: Coefficient words are taken one per cycle while `coef_valid` is high and no trial is running. In mode 0 the words fill b[0], b[1] and so on up to b[FIR_TAPS−1]. In mode 1 the first IIR_TAPS words fill b[0..IIR_TAPS−1] and the next IIR_TAPS words fill a[0..IIR_TAPS−1]. Words beyond that count are ignored. The load position returns to the first entry when a trial starts.
- R5: At the start of every trial, all earlier inputs and outputs are treated as zero. Nothing carries over from a previous trial.
- R6: A scaled result above 32767 becomes 32767, and one below −32768 becomes −32768.
- R7: `in_ready` is high only while the engine waits for a sample. After a sample is accepted, `in_ready` stays low and `out_valid` rises after exactly L+1 clock edges, where L is FIR_TAPS in mode 0 and IIR_TAPS in mode 1.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change.
- R9: A `start` pulse is taken only when the engine is idle. `busy` stays high from that point until `done`, which is a one-cycle pulse that follows the handshake of output TRIAL_LEN. A `start` pulse during a trial has no effect.
- R10: A coefficient word offered while `busy` is high does not change any coefficient. It sets `coef_err`, which then stays at 1 until reset.
- R11: The mode is captured when `start` is taken. Changing the `mode` input during a trial does not alter that trial's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 1 | 0 feedforward, 1 feedback; steers loading and is captured at start |
| coef_valid | input | 1 | Coefficient word present |
| coef_data | input | 16 | Coefficient word, Q4.12 |
| start | input | 1 | Begin a trial (idle only) |
| busy | output | 1 | A trial is in progress |
| done | output | 1 | One-cycle pulse after the last output of a trial |
| coef_err | output | 1 | Sticky: a coefficient word arrived during a trial |
| in_valid | input | 1 | Sample present |
| in_ready | output | 1 | Engine accepts a sample |
| in_data | input | 16 | Input sample, Q4.12 |
| out_valid | output | 1 | Filtered sample present |
| out_ready | input | 1 | Consumer accepts the output |
| out_data | output | 16 | Filtered sample, Q4.12 |

## Verification
The bench builds the engine with FIR_TAPS = 8, IIR_TAPS = 4 and TRIAL_LEN = 6. With these values every tap of both filter kinds and the full end of a trial can be exercised in a few hundred cycles. Because the trial is shorter than the feedforward length, the history mask at the start of a trial matters for every output, and it is checked on both halves of the tap range. The small feedback length still covers several recursion steps through the feedback memory, including the wrap of its read pointer. Saturation is driven in both directions, and rounding toward minus infinity is checked on odd negative products.

// File: rtl/filt_eng_pkg.sv
// Shared types of the trial filter engine.
// Assumes: nothing beyond the 1-bit mode encoding used at the top ports.
package filt_eng_pkg;

    typedef enum logic {
        MODE_FF = 1'b0,
        MODE_FB = 1'b1
    } filt_mode_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_MAC,
        ST_FIN,
        ST_OUT,
        ST_DONE
    } eng_state_t;

endpackage

// File: rtl/filt_hist_ring.sv
// Circular history memory: one write port, one asynchronous read port.
// Assumes: the caller masks entries that are older than the trial, so the
// contents need no reset.
module filt_hist_ring #(
    parameter int DEPTH = 8,
    parameter int DW    = 16,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic                 clk,
    input  logic                 we,
    input  logic [AW-1:0]        waddr,
    input  logic signed [DW-1:0] wdata,
    input  logic [AW-1:0]        raddr,
    output logic signed [DW-1:0] rdata
);

    logic signed [DW-1:0] mem [DEPTH];

    // Store the newest history entry.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/filt_coef_store.sv
// Two coefficient banks: feedforward (NB entries) and feedback (NA entries).
// Assumes: the writer never writes an index past its bank. Reset clears
// both banks, so taps that are never loaded act as zero.
module filt_coef_store #(
    parameter int DW  = 16,
    parameter int NB  = 8,
    parameter int NA  = 4,
    parameter int BAW = $clog2(NB),
    parameter int AAW = $clog2(NA)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 b_we,
    input  logic [BAW-1:0]       b_waddr,
    input  logic                 a_we,
    input  logic [AAW-1:0]       a_waddr,
    input  logic signed [DW-1:0] wdata,
    input  logic [BAW-1:0]       b_raddr,
    input  logic [AAW-1:0]       a_raddr,
    output logic signed [DW-1:0] b_rdata,
    output logic signed [DW-1:0] a_rdata
);

    logic signed [DW-1:0] b_mem [NB];
    logic signed [DW-1:0] a_mem [NA];

    // Feedforward bank: cleared on reset, written during a load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NB; i++) b_mem[i] <= '0;
        end else if (b_we) begin
            b_mem[b_waddr] <= wdata;
        end
    end

    // Feedback bank: cleared on reset, written during a load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NA; i++) a_mem[i] <= '0;
        end else if (a_we) begin
            a_mem[a_waddr] <= wdata;
        end
    end

    assign b_rdata = b_mem[b_raddr];
    assign a_rdata = a_mem[a_raddr];

endmodule

// File: rtl/filt_mac.sv
// Multiply-accumulate unit with scale-back and saturation.
// Each enabled cycle adds coef_b*samp_x and, when use_fb is set, subtracts
// coef_a*hist_y. The result is acc >>> FRAC, clamped to the DW-bit range.
// Assumes: clr and en are never high together.
module filt_mac #(
    parameter int DW    = 16,
    parameter int FRAC  = 12,
    parameter int ACC_W = 40
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 en,
    input  logic signed [DW-1:0] coef_b,
    input  logic signed [DW-1:0] samp_x,
    input  logic                 use_fb,
    input  logic signed [DW-1:0] coef_a,
    input  logic signed [DW-1:0] hist_y,
    output logic signed [DW-1:0] result
);

    localparam logic signed [ACC_W-1:0] SAT_HI = ACC_W'((64'sd1 <<< (DW-1)) - 64'sd1);
    localparam logic signed [ACC_W-1:0] SAT_LO = ~SAT_HI;

    logic signed [2*DW-1:0]  prod_b, prod_a;
    logic signed [ACC_W-1:0] term_b, term_a, acc, scaled;

    assign prod_b = coef_b * samp_x;
    assign prod_a = coef_a * hist_y;
    assign term_b = ACC_W'(prod_b);
    assign term_a = use_fb ? ACC_W'(prod_a) : '0;

    // Accumulate one tap per enabled cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            acc <= '0;
        end else if (en) begin
            acc <= acc + term_b - term_a;
        end
    end

    assign scaled = acc >>> FRAC;

    // Clamp the scaled sum to the output range.
    always_comb begin
        if (scaled > SAT_HI) begin
            result = {1'b0, {(DW-1){1'b1}}};
        end else if (scaled < SAT_LO) begin
            result = {1'b1, {(DW-1){1'b0}}};
        end else begin
            result = scaled[DW-1:0];
        end
    end

endmodule

// File: rtl/trial_filter_engine.sv
// Trial filter engine: loads coefficients serially, then filters TRIAL_LEN
// samples one tap per cycle in feedforward or feedback mode.
// Assumes: FIR_TAPS >= IIR_TAPS >= 2 and TRIAL_LEN >= 1. Inputs are held
// steady during a load. Histories are masked, not cleared, at trial start.
module trial_filter_engine
    import filt_eng_pkg::*;
#(
    parameter int DW        = 16,
    parameter int FRAC      = 12,
    parameter int FIR_TAPS  = 500,
    parameter int IIR_TAPS  = 128,
    parameter int TRIAL_LEN = 500
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode,
    input  logic          coef_valid,
    input  logic [DW-1:0] coef_data,
    input  logic          start,
    output logic          busy,
    output logic          done,
    output logic          coef_err,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [DW-1:0] in_data,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [DW-1:0] out_data
);

    localparam int KW    = $clog2(FIR_TAPS + 1);
    localparam int NW    = $clog2(TRIAL_LEN + 1);
    localparam int CW    = (KW > NW) ? KW : NW;
    localparam int XAW   = $clog2(FIR_TAPS);
    localparam int YAW   = $clog2(IIR_TAPS);
    localparam int LW    = $clog2(FIR_TAPS + 2 * IIR_TAPS + 1);
    localparam int ACC_W = 2 * DW + $clog2(FIR_TAPS) + 2;

    eng_state_t state;
    filt_mode_t mode_q;
    logic [KW-1:0]  k, last_k;
    logic [NW-1:0]  idx;
    logic [XAW-1:0] xwr, xrd;
    logic [YAW-1:0] ywr, yrd;
    logic [LW-1:0]  ld_ptr, ld_limit, a_off;
    logic           load_ok, b_we, a_we, x_ok, y_ok, accept, emit;
    logic signed [DW-1:0] b_rd, a_rd, x_rd, y_rd, mac_res, out_q;

    function automatic logic [XAW-1:0] x_step_back(input logic [XAW-1:0] p);
        return (p == '0) ? XAW'(FIR_TAPS - 1) : p - XAW'(1);
    endfunction
    function automatic logic [XAW-1:0] x_step_fwd(input logic [XAW-1:0] p);
        return (p == XAW'(FIR_TAPS - 1)) ? '0 : p + XAW'(1);
    endfunction
    function automatic logic [YAW-1:0] y_step_back(input logic [YAW-1:0] p);
        return (p == '0) ? YAW'(IIR_TAPS - 1) : p - YAW'(1);
    endfunction
    function automatic logic [YAW-1:0] y_step_fwd(input logic [YAW-1:0] p);
        return (p == YAW'(IIR_TAPS - 1)) ? '0 : p + YAW'(1);
    endfunction

    assign busy      = (state != ST_IDLE) && (state != ST_DONE);
    assign done      = (state == ST_DONE);
    assign in_ready  = (state == ST_WAIT);
    assign out_valid = (state == ST_OUT);
    assign out_data  = out_q;
    assign accept    = in_valid && in_ready;
    assign emit      = out_valid && out_ready;
    assign last_k    = (mode_q == MODE_FB) ? KW'(IIR_TAPS - 1) : KW'(FIR_TAPS - 1);

    // Coefficient load steering: the live mode picks the word layout.
    assign ld_limit = (filt_mode_t'(mode) == MODE_FB) ? LW'(2 * IIR_TAPS) : LW'(FIR_TAPS);
    assign load_ok  = coef_valid && !busy && (ld_ptr < ld_limit);
    assign a_off    = ld_ptr - LW'(IIR_TAPS);
    assign b_we     = load_ok && ((filt_mode_t'(mode) == MODE_FF) || (ld_ptr < LW'(IIR_TAPS)));
    assign a_we     = load_ok && (filt_mode_t'(mode) == MODE_FB) && (ld_ptr >= LW'(IIR_TAPS));

    // History masks: a tap reaches before the trial only if k exceeds idx.
    assign x_ok = (CW'(k) <= CW'(idx));
    assign y_ok = (mode_q == MODE_FB) && (k != '0) && (CW'(k) <= CW'(idx));

    filt_coef_store #(.DW(DW), .NB(FIR_TAPS), .NA(IIR_TAPS), .BAW(XAW), .AAW(YAW)) u_coef (
        .clk(clk), .rst_n(rst_n),
        .b_we(b_we), .b_waddr(ld_ptr[XAW-1:0]),
        .a_we(a_we), .a_waddr(a_off[YAW-1:0]),
        .wdata(coef_data),
        .b_raddr(k[XAW-1:0]), .a_raddr(k[YAW-1:0]),
        .b_rdata(b_rd), .a_rdata(a_rd)
    );

    filt_hist_ring #(.DEPTH(FIR_TAPS), .DW(DW), .AW(XAW)) u_xhist (
        .clk(clk), .we(accept), .waddr(xwr), .wdata(in_data),
        .raddr(xrd), .rdata(x_rd)
    );

    filt_hist_ring #(.DEPTH(IIR_TAPS), .DW(DW), .AW(YAW)) u_yhist (
        .clk(clk), .we(state == ST_FIN), .waddr(ywr), .wdata(mac_res),
        .raddr(yrd), .rdata(y_rd)
    );

    filt_mac #(.DW(DW), .FRAC(FRAC), .ACC_W(ACC_W)) u_mac (
        .clk(clk), .rst_n(rst_n),
        .clr(accept), .en(state == ST_MAC),
        .coef_b(b_rd), .samp_x(x_ok ? x_rd : '0),
        .use_fb(y_ok), .coef_a(a_rd), .hist_y(y_ok ? y_rd : '0),
        .result(mac_res)
    );

    // Load pointer: advance per accepted word, rewind when a trial starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_ptr <= '0;
        end else if (state == ST_IDLE && start) begin
            ld_ptr <= '0;
        end else if (load_ok) begin
            ld_ptr <= ld_ptr + LW'(1);
        end
    end

    // Sticky flag for coefficient words offered during a trial.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            coef_err <= 1'b0;
        end else if (coef_valid && busy) begin
            coef_err <= 1'b1;
        end
    end

    // Trial sequencer: wait, multiply-accumulate, scale, hand out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            mode_q <= MODE_FF;
            k      <= '0;
            idx    <= '0;
            xwr    <= '0;
            xrd    <= '0;
            ywr    <= '0;
            yrd    <= '0;
            out_q  <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    state  <= ST_WAIT;
                    mode_q <= filt_mode_t'(mode);
                    idx    <= '0;
                    xwr    <= '0;
                    ywr    <= '0;
                end
                ST_WAIT: if (in_valid) begin
                    state <= ST_MAC;
                    k     <= '0;
                    xrd   <= xwr;
                    yrd   <= y_step_back(ywr);
                end
                ST_MAC: begin
                    xrd <= x_step_back(xrd);
                    if (k != '0) yrd <= y_step_back(yrd);
                    if (k == last_k) state <= ST_FIN;
                    else             k <= k + KW'(1);
                end
                ST_FIN: begin
                    out_q <= mac_res;
                    state <= ST_OUT;
                end
                ST_OUT: if (out_ready) begin
                    xwr <= x_step_fwd(xwr);
                    ywr <= y_step_fwd(ywr);
                    idx <= idx + NW'(1);
                    state <= (idx == NW'(TRIAL_LEN - 1)) ? ST_DONE : ST_WAIT;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Port-level checks placed beside the sequencer.
    p_no_accept_while_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && out_valid));
    p_accept_blocks_input_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);
    p_out_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));
    p_done_after_emit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(out_valid && out_ready));
    p_err_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (coef_valid && busy) |=> coef_err);
    p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        coef_err |=> coef_err);

endmodule

// File: tb/trial_filter_engine_bench.sv
// Scoreboard bench: drivers push expected outputs, a monitor pops and compares.
module trial_filter_engine_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NB = 8;
    localparam int NA = 4;
    localparam int TL = 6;

    logic clk = 1'b0, rst_n = 1'b0, mode = 1'b0, coef_valid = 1'b0, start = 1'b0;
    logic in_valid = 1'b0, out_ready = 1'b1;
    logic [15:0] coef_data = '0, in_data = '0;
    logic busy, done, coef_err, in_ready, out_valid;
    logic [15:0] out_data;

    trial_filter_engine #(.FIR_TAPS(NB), .IIR_TAPS(NA), .TRIAL_LEN(TL)) u_trial_filter_engine (
        .clk(clk), .rst_n(rst_n), .mode(mode), .coef_valid(coef_valid),
        .coef_data(coef_data), .start(start), .busy(busy), .done(done),
        .coef_err(coef_err), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_chk = 0, n_err = 0, n_out = 0;
    logic signed [15:0] bq [NB];
    logic signed [15:0] aq [NA];
    logic signed [15:0] stim [TL];
    logic signed [15:0] ys [TL];
    logic signed [15:0] expq [$];
    string cur_req = "R2";

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic signed [15:0] model(input bit md, input int i);
        longint acc = 0;
        longint sh;
        int len = md ? NA : NB;
        for (int k = 0; k < len; k++) begin
            if (k <= i) acc += longint'(bq[k]) * longint'(stim[i-k]);
            if (md && k >= 1 && k <= i) acc -= longint'(aq[k]) * longint'(ys[i-k]);
        end
        sh = acc >>> 12;
        if (sh > 32767) return 16'sd32767;
        if (sh < -32768) return -16'sd32768;
        return 16'(sh);
    endfunction

    // Monitor: pop and compare on every output handshake.
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            n_out++;
            if (expq.size() == 0) begin
                chk(1'b0, cur_req, int'($signed(out_data)), 0);
            end else begin
                logic signed [15:0] e;
                e = expq.pop_front();
                chk($signed(out_data) == e, cur_req, int'($signed(out_data)), int'(e));
            end
        end
    end

    task automatic load_coefs(input bit md, input int extra);
        int n = md ? 2 * NA : NB;
        @(posedge clk); #1;
        mode = md;
        for (int i = 0; i < n + extra; i++) begin
            coef_valid = 1'b1;
            if (i >= n)      coef_data = 16'h3000;
            else if (!md)    coef_data = bq[i];
            else if (i < NA) coef_data = bq[i];
            else             coef_data = aq[i-NA];
            @(posedge clk); #1;
        end
        coef_valid = 1'b0;
    endtask

    task automatic pulse_start();
        @(posedge clk); #1 start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
    endtask

    // Driver: send one sample, push its expected output, check latency (R7).
    task automatic send_sample(input bit md, input int i);
        int lows = 0;
        ys[i] = model(md, i);
        expq.push_back(ys[i]);
        in_valid = 1'b1;
        in_data  = stim[i];
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        @(posedge clk); #1 in_valid = 1'b0;
        @(negedge clk);
        while (!out_valid && lows < 100) begin
            chk(!in_ready, "R7", int'(in_ready), 0);
            lows++;
            @(negedge clk);
        end
        chk(lows == (md ? NA : NB) + 1, "R7", lows, (md ? NA : NB) + 1);
        @(posedge clk); #1;
    endtask

    task automatic run_trial(input bit md, input string req);
        int waited = 0;
        cur_req = req;
        n_out = 0;
        mode = md;
        pulse_start();
        @(negedge clk);
        chk(busy, "R9", int'(busy), 1);
        @(posedge clk); #1;
        for (int i = 0; i < TL; i++) send_sample(md, i);
        @(negedge clk);
        while (!done && waited < 200) begin
            waited++;
            @(negedge clk);
        end
        chk(done, "R9", int'(done), 1);
        chk(n_out == TL, "R9", n_out, TL);
        chk(!busy, "R9", int'(busy), 0);
        chk(expq.size() == 0, req, expq.size(), 0);
        @(negedge clk);
        chk(!done, "R9", int'(done), 0);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual hung expected finish");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(!busy, "R1", int'(busy), 0);
        chk(!done, "R1", int'(done), 0);
        chk(!coef_err, "R1", int'(coef_err), 0);
        chk(!in_ready, "R1", int'(in_ready), 0);
        chk(!out_valid, "R1", int'(out_valid), 0);
        @(posedge clk); #1 rst_n = 1'b1;

        // R2 and R4: feedforward load with two surplus words, then a trial
        bq = '{16'sh1000, 16'sh0800, -16'sh0400, 16'sh0200, 16'sh0000, 16'sh0000, 16'sh0100, -16'sh0100};
        stim = '{16'sh0400, -16'sh0200, 16'sh0100, 16'sh0800, -16'sh0800, 16'sh0010};
        load_coefs(1'b0, 2);
        run_trial(1'b0, "R2_R4");
        // R5: the same trial again starts from zeroed history
        run_trial(1'b0, "R5");

        // R3: feedback mode with a nonzero a[0] that must be unused
        bq = '{16'sh0800, 16'sh0400, -16'sh0200, 16'sh0100, 16'sh0, 16'sh0, 16'sh0, 16'sh0};
        aq = '{16'sh7FFF, -16'sh0C00, 16'sh0400, -16'sh0100};
        stim = '{16'sh1000, 16'sh0000, -16'sh0800, 16'sh0400, 16'sh0000, 16'sh0200};
        load_coefs(1'b1, 0);
        // R11: mode input flipped during the trial has no effect
        fork
            run_trial(1'b1, "R3_R11");
            begin
                repeat (4) @(posedge clk);
                #1 mode = 1'b0;
            end
        join

        // R8: hold the first output under backpressure
        out_ready = 1'b0;
        fork
            run_trial(1'b1, "R8");
            begin
                logic [15:0] held;
                @(negedge clk);
                while (!out_valid) @(negedge clk);
                held = out_data;
                repeat (3) begin
                    @(negedge clk);
                    chk(out_valid, "R8", int'(out_valid), 1);
                    chk(out_data == held, "R8", int'(out_data), int'(held));
                end
                @(posedge clk); #1 out_ready = 1'b1;
            end
        join

        // R6: saturation in both directions
        bq = '{16'sh7FFF, 16'sh0, 16'sh0, 16'sh0, 16'sh0, 16'sh0, 16'sh0, 16'sh0};
        stim = '{16'sh7000, -16'sh7000, 16'sh0001, 16'sh0000, -16'sh0001, 16'sh7FFF};
        load_coefs(1'b0, 0);
        run_trial(1'b0, "R6");

        // R2: floor rounding of odd negative products
        bq = '{16'sh0800, 16'sh0, 16'sh0, 16'sh0, 16'sh0, 16'sh0, 16'sh0, 16'sh0};
        stim = '{-16'sh0001, 16'sh0001, -16'sh0003, 16'sh0003, -16'sh0002, 16'sh0000};
        load_coefs(1'b0, 0);
        run_trial(1'b0, "R2");

        // R10 and R9: coefficient word and start pulse during a trial
        fork
            run_trial(1'b0, "R10");
            begin
                repeat (6) @(posedge clk);
                #1 coef_valid = 1'b1; coef_data = 16'h7FFF; start = 1'b1;
                @(posedge clk); #1 coef_valid = 1'b0; start = 1'b0;
                @(negedge clk);
                chk(coef_err, "R10", int'(coef_err), 1);
            end
        join
        // R10: flag still set, coefficients unchanged in a further trial
        run_trial(1'b0, "R10");
        chk(coef_err, "R10", int'(coef_err), 1);

        finish_run();
    end

endmodule